// File: doc/BRIEF.md
# Microprogram Sequencer Next-Address Unit

This block steps a horizontally microcoded control unit through its microprogram. It holds a 512-word by 36-bit control store and a microinstruction register (MIR). Each cycle it forms the address of the next microinstruction (MPC) from the current MIR, two latched condition flags (negative and zero) and the opcode byte from the instruction byte buffer. It then loads the word at that address into the MIR. Branches are made by OR-ing bits into the address field, never by adding an offset. A flag-controlled bit gives two-way branches, and OR-ing the opcode byte into the low eight bits gives a 256-way dispatch. A microinstruction whose next-address field has bit 8 set opens a second 256-entry dispatch table, which serves opcodes that follow a widening prefix.

The block also decodes the 4-bit source-select field of the MIR into one-hot read enables for the nine registers that can drive the datapath's B operand bus. Software or a test harness fills the control store through a synchronous write port. That port works while the block is held in reset, so the microprogram can be loaded before execution starts.

Top module: `mseq_top`

## Requirements
- R1: Reset is asynchronous and active low, and its release is synchronised over two clock edges. On the first clock edge after the synchronised release, MPC stays 0 and the MIR is loaded with control-store word 0.
- R2: Bit 8 of the next MPC is next-address bit 8, OR'd with (JAMN AND flag_n), OR'd with (JAMZ AND flag_z). JAMN is MIR bit 25 and JAMZ is MIR bit 24.
- R3: When JMPC (MIR bit 26) is 1, bits 7:0 of the next MPC are next-address bits 7:0 OR'd with the `mbr` byte.
- R4: When JMPC is 0, bits 7:0 of the next MPC equal next-address bits 7:0 and `mbr` has no effect. When JAMN and JAMZ are both 0, the flags have no effect.
- R5: A word with next address 0x100 and JMPC set dispatches to 0x100 OR `mbr`, which selects the second dispatch table.
- R6: After every clock edge outside the boot edge, `mpc` holds the computed next address and `mir` holds the control-store word at that address.
- R7: MIR bits 3:0 select the B-bus source. Codes 0 to 8 set exactly bit k of `bsel_oh`, in this order: MDR, PC, MBR, MBRU, SP, LV, CPP, TOS, OPC.
- R8: Source-select codes 9 to 15 drive every `bsel_oh` bit to 0.
- R9: A write with `cs_we` high stores `cs_wdata` at `cs_waddr` on the clock edge, including while reset is asserted. Words that are not written keep their contents across a reset.
- R10: The MIR fields lie at fixed positions: next address 35:27, JMPC 26, JAMN 25, JAMZ 24, ALU/shifter control 23:16, C-bus write enables 15:7, memory control 6:4, B-bus select 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_we | input | 1 | Control-store write enable |
| cs_waddr | input | 9 | Control-store write address |
| cs_wdata | input | 36 | Control-store write data |
| flag_n | input | 1 | Latched negative flag |
| flag_z | input | 1 | Latched zero flag |
| mbr | input | 8 | Opcode byte for dispatch |
| mpc | output | 9 | Address of the word now held in the MIR |
| mir | output | 36 | Current microinstruction |
| bsel_oh | output | 9 | One-hot B-bus source enables |

## Verification
On every cycle, the assertions check the following:
- The boot edge keeps MPC at 0.
- The high MPC bit follows the next-address bit and the enabled flags.
- The low MPC bits copy the next-address field when JMPC is clear, and contain every bit of that field when JMPC is set.
- The source enables are one-hot for codes 0 to 8 and all zero for codes 9 to 15.

Only the bench scenarios can show the following:
- The MIR really holds the stored word at the new MPC.
- The exact OR with the opcode byte, including the second dispatch table.
- The loading of the store while reset is asserted.

To show these, the bench walks the whole 512-word store under pseudo-random flags and opcodes and runs directed dispatch chains.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  localparam int unsigned OP_W   = 8;
  localparam int unsigned ADDR_W = OP_W + 1;
  localparam int unsigned ALU_W  = 8;
  localparam int unsigned CWR_W  = 9;
  localparam int unsigned MEM_W  = 3;
  localparam int unsigned BSEL_W = 4;
  localparam int unsigned NSRC   = 9;
  localparam int unsigned JMP_W  = 3;
  localparam int unsigned WORD_W = ADDR_W + JMP_W + ALU_W + CWR_W + MEM_W + BSEL_W;
  localparam int unsigned DEPTH  = 1 << ADDR_W;

  // Field order is behaviour: neighbours decode these positions.
  typedef struct packed {
    logic [ADDR_W-1:0] nxt;
    logic              jmpc;
    logic              jamn;
    logic              jamz;
    logic [ALU_W-1:0]  alu;
    logic [CWR_W-1:0]  cwr;
    logic [MEM_W-1:0]  mem;
    logic [BSEL_W-1:0] bsel;
  } uword_t;

endpackage

// File: rtl/mseq_rst_sync.sv
module mseq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/mseq_cstore.sv
module mseq_cstore
  import mseq_pkg::*;
#(
  parameter int unsigned A_W = ADDR_W,
  parameter int unsigned D_W = WORD_W,
  localparam int unsigned N_WORDS = 1 << A_W
) (
  input  logic           clk,
  input  logic           wr_en,
  input  logic [A_W-1:0] wr_addr,
  input  logic [D_W-1:0] wr_data,
  input  logic [A_W-1:0] rd_addr,
  output logic [D_W-1:0] rd_data
);

  logic [D_W-1:0] store_q [N_WORDS];

  // Storage array: no reset, written through the clock-enabled port only.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      store_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = store_q[rd_addr];

endmodule

// File: rtl/mseq_next_addr.sv
module mseq_next_addr
  import mseq_pkg::*;
(
  input  logic [ADDR_W-1:0] na_field,
  input  logic              jmpc,
  input  logic              jamn,
  input  logic              jamz,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic [OP_W-1:0]   opcode,
  output logic [ADDR_W-1:0] next_addr
);

  logic cond_hit;
  logic [OP_W-1:0] low_part;

  always_comb begin
    cond_hit = (jamn & flag_n) | (jamz & flag_z);
  end

  always_comb begin
    if (jmpc) begin
      low_part = na_field[OP_W-1:0] | opcode;
    end else begin
      low_part = na_field[OP_W-1:0];
    end
  end

  always_comb begin
    next_addr           = na_field;
    next_addr[OP_W]     = na_field[OP_W] | cond_hit;
    next_addr[OP_W-1:0] = low_part;
  end

endmodule

// File: rtl/mseq_bsel_dec.sv
module mseq_bsel_dec
  import mseq_pkg::*;
#(
  parameter int unsigned CODE_W = BSEL_W,
  parameter int unsigned N_OUT  = NSRC
) (
  input  logic [CODE_W-1:0] code,
  output logic [N_OUT-1:0]  sel_oh
);

  generate
    for (genvar k = 0; k < N_OUT; k++) begin : g_src
      assign sel_oh[k] = (code == CODE_W'(k));
    end
  endgenerate

endmodule

// File: rtl/mseq_top.sv
module mseq_top
  import mseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_we,
  input  logic [ADDR_W-1:0] cs_waddr,
  input  logic [WORD_W-1:0] cs_wdata,
  input  logic              flag_n,
  input  logic              flag_z,
  input  logic [OP_W-1:0]   mbr,
  output logic [ADDR_W-1:0] mpc,
  output logic [WORD_W-1:0] mir,
  output logic [NSRC-1:0]   bsel_oh
);

  logic              rst_sync_n;
  logic [ADDR_W-1:0] mpc_q, mpc_d;
  uword_t            mir_q, mir_d;
  logic              boot_q, boot_d;
  logic [ADDR_W-1:0] computed_addr;
  logic [ADDR_W-1:0] fetch_addr;
  logic [WORD_W-1:0] fetch_word;
  logic              seq_en;

  mseq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mseq_next_addr u_next (
    .na_field  (mir_q.nxt),
    .jmpc      (mir_q.jmpc),
    .jamn      (mir_q.jamn),
    .jamz      (mir_q.jamz),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .opcode    (mbr),
    .next_addr (computed_addr)
  );

  mseq_cstore #(.A_W(ADDR_W), .D_W(WORD_W)) u_store (
    .clk     (clk),
    .wr_en   (cs_we),
    .wr_addr (cs_waddr),
    .wr_data (cs_wdata),
    .rd_addr (fetch_addr),
    .rd_data (fetch_word)
  );

  mseq_bsel_dec #(.CODE_W(BSEL_W), .N_OUT(NSRC)) u_bdec (
    .code   (mir_q.bsel),
    .sel_oh (bsel_oh)
  );

  // Next-state logic
  always_comb begin
    seq_en     = 1'b1;
    fetch_addr = boot_q ? '0 : computed_addr;
    mpc_d      = fetch_addr;
    mir_d      = uword_t'(fetch_word);
    boot_d     = 1'b0;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mpc_q  <= '0;
      mir_q  <= '0;
      boot_q <= 1'b1;
    end else if (seq_en) begin
      mpc_q  <= mpc_d;
      mir_q  <= mir_d;
      boot_q <= boot_d;
    end
  end

  assign mpc = mpc_q;
  assign mir = mir_q;

  // R1: boot edge keeps address 0
  p_boot_zero_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    boot_q |=> (mpc_q == '0));

  // R2: high bit forced by field or enabled flag
  p_hi_set_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!boot_q && (mir_q.nxt[OP_W] || (mir_q.jamn && flag_n) || (mir_q.jamz && flag_z)))
    |=> mpc_q[OP_W]);

  p_hi_clr_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!boot_q && !mir_q.nxt[OP_W] && !(mir_q.jamn && flag_n) && !(mir_q.jamz && flag_z))
    |=> !mpc_q[OP_W]);

  // R3: dispatch never clears a bit of the field
  p_low_or_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!boot_q && mir_q.jmpc)
    |=> ((mpc_q[OP_W-1:0] & $past(mir_q.nxt[OP_W-1:0])) == $past(mir_q.nxt[OP_W-1:0])));

  // R4: without dispatch the low bits copy the field
  p_low_copy_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!boot_q && !mir_q.jmpc) |=> (mpc_q[OP_W-1:0] == $past(mir_q.nxt[OP_W-1:0])));

  // R7: valid codes give exactly one enable
  p_bsel_one_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (32'(mir_q.bsel) < NSRC) |-> ($countones(bsel_oh) == 1));

  // R8: codes above the source count give none
  p_bsel_none_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (32'(mir_q.bsel) >= NSRC) |-> (bsel_oh == '0));

endmodule

// File: tb/test_mseq_top.sv
module test_mseq_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_we;
  logic [8:0]  cs_waddr;
  logic [35:0] cs_wdata;
  logic        flag_n, flag_z;
  logic [7:0]  mbr;
  logic [8:0]  mpc;
  logic [35:0] mir;
  logic [8:0]  bsel_oh;

  int n_chk = 0;
  int n_fail = 0;
  logic [35:0] model_mem [512];
  logic [35:0] m_mir;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  mseq_top i_mseq_top (
    .clk(clk), .rst_n(rst_n), .cs_we(cs_we), .cs_waddr(cs_waddr),
    .cs_wdata(cs_wdata), .flag_n(flag_n), .flag_z(flag_z), .mbr(mbr),
    .mpc(mpc), .mir(mir), .bsel_oh(bsel_oh)
  );

  function automatic logic [35:0] gen_word(int a);
    logic [8:0] na;  logic [2:0] jc;  logic [7:0] alu;
    logic [8:0] cw;  logic [2:0] mm;  logic [3:0] b;
    na  = 9'((a * 97 + 13) % 512);
    jc  = 3'((a ^ (a >> 3)) & 7);
    alu = 8'(a & 255) ^ 8'h5A;
    cw  = 9'((a * 3) % 512);
    mm  = 3'(a % 8);
    b   = 4'((a * 7) % 16);
    return {na, jc, alu, cw, mm, b};
  endfunction

  // Fields at 35:27 next, 26 JMPC, 25 JAMN, 24 JAMZ (R10)
  function automatic logic [8:0] next_of(logic [35:0] w, logic n, logic z, logic [7:0] op);
    logic [8:0] r;
    r    = w[35:27];
    r[8] = w[35] | (w[25] & n) | (w[24] & z);
    if (w[26]) r[7:0] = w[34:27] | op;
    return r;
  endfunction

  function automatic logic [8:0] bsel_of(logic [35:0] w);
    return (w[3:0] < 4'd9) ? (9'd1 << w[3:0]) : 9'd0;
  endfunction

  task automatic chk(bit ok, string tag, logic [35:0] act, logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [35:0] d);
    @(negedge clk);
    cs_we = 1'b1; cs_waddr = 9'(a); cs_wdata = d;
    model_mem[a] = d;
  endtask

  task automatic release_and_boot(string tag);
    @(negedge clk);
    cs_we = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    m_mir = model_mem[0];
    chk(mpc == 9'd0, {tag, " R1 mpc"}, 36'(mpc), 36'd0);
    chk(mir == m_mir, {tag, " R1 R9 mir"}, mir, m_mir);
  endtask

  task automatic step(logic n, logic z, logic [7:0] op, string tag);
    logic [8:0] e_mpc;
    flag_n = n; flag_z = z; mbr = op;
    e_mpc = next_of(m_mir, n, z, op);
    m_mir = model_mem[e_mpc];
    @(posedge clk);
    @(negedge clk);
    chk(mpc == e_mpc, {tag, " R2 R3 R4 mpc"}, 36'(mpc), 36'(e_mpc));
    chk(mir == m_mir, {tag, " R6 mir"}, mir, m_mir);
    chk(bsel_oh == bsel_of(m_mir), {tag, " R7 R8 bsel"}, 36'(bsel_oh), 36'(bsel_of(m_mir)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_we = 1'b0; cs_waddr = '0; cs_wdata = '0;
    flag_n = 1'b0; flag_z = 1'b0; mbr = '0;
    // R9: fill whole store during reset
    for (int a = 0; a < 512; a++) wr(a, gen_word(a));
    release_and_boot("sweep");
    // Outputs during boot cycle: bsel from word 0
    chk(bsel_oh == bsel_of(m_mir), "sweep R7 boot bsel", 36'(bsel_oh), 36'(bsel_of(m_mir)));
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], lfsr[1], lfsr[15:8], "sweep");
    end

    // Directed dispatch chain, store reloaded in reset (R5, R9)
    @(negedge clk);
    rst_n = 1'b0;
    wr(9'h000, {9'h100, 3'b100, 8'h00, 9'h000, 3'd0, 4'd9});
    wr(9'h1C4, {9'h005, 3'b001, 8'h11, 9'h1FF, 3'd2, 4'd2});
    wr(9'h105, {9'h0AA, 3'b000, 8'h22, 9'h001, 3'd1, 4'd8});
    wr(9'h0AA, {9'h055, 3'b010, 8'h33, 9'h100, 3'd4, 4'd0});
    release_and_boot("chain");
    chk(bsel_oh == 9'd0, "chain R8 code9", 36'(bsel_oh), 36'd0);
    step(1'b0, 1'b0, 8'hC4, "chain R5 wide");
    chk(mpc == 9'h1C4, "chain R5 second table", 36'(mpc), 36'h1C4);
    step(1'b1, 1'b1, 8'hFF, "chain R2 jamz");
    chk(mpc == 9'h105, "chain R2 jamz taken", 36'(mpc), 36'h105);
    step(1'b1, 1'b1, 8'hFF, "chain R4 ignore");
    chk(mpc == 9'h0AA, "chain R4 flags/mbr ignored", 36'(mpc), 36'h0AA);
    chk(bsel_oh == 9'd1, "chain R7 code0 MDR", 36'(bsel_oh), 36'd1);
    step(1'b0, 1'b1, 8'hFF, "chain R2 jamn clear");
    chk(mpc == 9'h055, "chain R2 jamn not taken", 36'(mpc), 36'h055);
    chk(mir == gen_word(9'h055), "chain R9 kept word", mir, gen_word(9'h055));
    for (int i = 0; i < 40; i++) step(i[0], i[1], 8'(i * 37), "chain tail");

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule